// File: doc/BRIEF.md
# Nanosecond-Period Oversampling Tick Generator

This block produces the oversampling strobe for a UART from a divisor that gives the sample period as a time in nanoseconds, not as a count of input clocks. The divisor has an integer part in nanoseconds and a fractional part in units of 1/255 ns. A free-running reference clock of known period advances a phase accumulator by that period on every edge. Each time the accumulated time reaches one programmed sample period, the block raises `sample_tick` for one cycle and carries the leftover fraction forward. The long-run tick rate therefore matches the programmed period exactly, even when that period is not a whole number of reference cycles.

A second strobe, `bit_tick`, marks every 8th or 16th sample tick. Software selects the oversampling ratio by writing one of two configuration codes. By convention the 8-sample mode is used at 4 Mbps and above, and the 16-sample mode at lower rates. The configuration code contains a transmit end-point field that software may clear for a short time. The decoder ignores that field, so clearing it does not change the mode. Both registers are loaded through a single-cycle write strobe.

Top module: `ns_baud_tick_gen`

## Requirements
- R1: After reset the divisor is zero, the mode is 16 samples per bit, and neither `sample_tick` nor `bit_tick` is asserted.
- R2: A write with `wr_sel`=0 loads the divisor. `wr_data[31:8]` is the integer period in ns, and `wr_data[7:0]` is the fraction in 1/255 ns. The sample threshold is T = integer*255 + fraction, in 1/255-ns units.
- R3: With step S = REF_PERIOD_NS*255 and T ≥ S, the number of sample ticks seen in the k cycles after a divisor write is exactly floor(k*S/T). Each tick lasts one cycle.
- R4: A divisor write clears the phase and the sample counter. No tick of either kind appears in the cycle after the write, and counting restarts from zero.
- R5: While the integer part of the divisor is zero, no ticks are produced, whatever the fraction.
- R6: In 16-sample mode, `bit_tick` is asserted together with every 16th sample tick counted from the last divisor write, and never without a sample tick.
- R7: In 8-sample mode, `bit_tick` is asserted together with every 8th sample tick.
- R8: A write with `wr_sel`=1 compares `wr_data` with bits 23:20 masked off. A match with 32'h26731000 selects 8-sample mode, and a match with 32'h6EF71000 selects 16-sample mode. Any other word leaves the mode unchanged.
- R9: When the programmed period is shorter than the reference period (T < S), a sample tick is produced on every cycle and never more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of period REF_PERIOD_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 divisor, 1 mode configuration |
| wr_data | input | 32 | Write data |
| sample_tick | output | 1 | One-cycle oversampling strobe |
| bit_tick | output | 1 | One-cycle strobe every 8th or 16th sample tick |

## Verification
The bench builds the block with REF_PERIOD_NS=5, which gives an accumulator step of 1275 and matches its 200 MHz clock. The divisor widths stay at their defaults of 24 and 8 bits. With these values, divisors of a few tens of nanoseconds give both exact-multiple and fractional periods, and they bring the 16th-sample bit strobe within a few hundred cycles. A 2 ns divisor sits below the reference period, which exercises the saturated one-tick-per-cycle case. The tick stream is predicted cycle by cycle with the floor formula, so any drift in the fractional carry shows up in the cycle where it occurs.

// File: rtl/ns_baud_tick_gen.sv
module ns_baud_tick_gen #(
  parameter int          REF_PERIOD_NS = 5,
  parameter int          INT_W         = 24,
  parameter int          FRAC_W        = 8,
  parameter logic [31:0] CODE_X8       = 32'h2673_1000,
  parameter logic [31:0] CODE_X16      = 32'h6EF7_1000,
  parameter int          EP_LSB        = 20,
  parameter int          EP_W          = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic        sample_tick,
  output logic        bit_tick
);
  localparam int ACC_W = INT_W + FRAC_W + 2;
  localparam logic [ACC_W-1:0] STEP  = ACC_W'(REF_PERIOD_NS * 255);
  localparam logic [ACC_W-1:0] DEN   = ACC_W'(255);
  localparam logic [31:0]      EP_MK = ~(((32'd1 << EP_W) - 32'd1) << EP_LSB);

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [ACC_W-1:0]  acc_q;
  logic [3:0]        cnt_q;
  logic              x8_q;

  logic [ACC_W-1:0] thr, sum, rem;
  logic             run, hit, wr_div, wr_cfg, bit_now;

  assign wr_div  = wr_en && !wr_sel;
  assign wr_cfg  = wr_en && wr_sel;
  assign thr     = ACC_W'(int_q) * DEN + ACC_W'(frac_q);
  assign run     = int_q != '0;
  assign sum     = acc_q + STEP;
  assign hit     = run && (sum >= thr);
  assign rem     = sum - thr;
  assign bit_now = (cnt_q[2:0] == 3'd7) && (x8_q || cnt_q[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q       <= '0;
      frac_q      <= '0;
      acc_q       <= '0;
      cnt_q       <= '0;
      x8_q        <= 1'b0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else if (wr_div) begin
      int_q       <= wr_data[FRAC_W +: INT_W];
      frac_q      <= wr_data[FRAC_W-1:0];
      acc_q       <= '0;
      cnt_q       <= '0;
      sample_tick <= 1'b0;
      bit_tick    <= 1'b0;
    end else begin
      if (wr_cfg) begin
        if ((wr_data & EP_MK) == (CODE_X8 & EP_MK))       x8_q <= 1'b1;
        else if ((wr_data & EP_MK) == (CODE_X16 & EP_MK)) x8_q <= 1'b0;
      end
      if (!run) begin
        acc_q       <= '0;
        sample_tick <= 1'b0;
        bit_tick    <= 1'b0;
      end else if (hit) begin
        acc_q       <= (rem >= thr) ? '0 : rem;
        cnt_q       <= cnt_q + 4'd1;
        sample_tick <= 1'b1;
        bit_tick    <= bit_now;
      end else begin
        acc_q       <= sum;
        sample_tick <= 1'b0;
        bit_tick    <= 1'b0;
      end
    end
  end

  p_bit_with_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> (!sample_tick && !bit_tick && acc_q == '0 && cnt_q == '0));

  p_idle_when_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0 && !wr_div) |=> !sample_tick);

  p_rem_below_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (acc_q < thr));

  p_x8_only_by_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(x8_q));
endmodule

// File: tb/ns_baud_tick_gen_bench.sv
`timescale 1ns/1ps
module ns_baud_tick_gen_bench;
  localparam int  REFNS = 5;
  localparam longint S  = REFNS * 255;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic sample_tick, bit_tick;
  int total = 0, bad = 0;

  ns_baud_tick_gen #(.REF_PERIOD_NS(REFNS)) u_ns_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick));

  always #2.5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [31:0] dv(input int ns, input int fr);
    return (32'(ns) << 8) | 32'(fr);
  endfunction

  // checks n cycles following a divisor write against the floor model
  task automatic run_chk(input int n, input longint thr, input int osr, input string req);
    longint mp, mn;
    logic et, eb;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (thr == 0) begin et = 0; eb = 0; end
      else begin
        mp = (thr <= S) ? longint'(k - 1) : (longint'(k - 1) * S) / thr;
        mn = (thr <= S) ? longint'(k)     : (longint'(k) * S) / thr;
        et = (mn != mp);
        eb = et && (mn % osr == 0);
      end
      chk(sample_tick, et, req, $sformatf("sample_tick cycle %0d", k));
      chk(bit_tick,    eb, req, $sformatf("bit_tick cycle %0d", k));
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(sample_tick, 1'b0, "R1", "sample_tick after reset");
      chk(bit_tick,    1'b0, "R1", "bit_tick after reset");
    end
  endtask

  task automatic t_default_mode;
    wr(1'b0, dv(20, 0));  // R1 default 16 mode, R2 integer decode
    run_chk(80, 20 * 255, 16, "R1");
  endtask

  task automatic t_integer;
    wr(1'b0, dv(20, 0));
    run_chk(200, 20 * 255, 16, "R2");
  endtask

  task automatic t_fraction;
    wr(1'b0, dv(12, 191));
    run_chk(300, 12 * 255 + 191, 16, "R3");
    wr(1'b0, dv(7, 3));
    run_chk(300, 7 * 255 + 3, 16, "R3");
  endtask

  task automatic t_phase_reset;
    wr(1'b1, 32'h2673_1000);
    wr(1'b0, dv(20, 0));
    repeat (22) @(negedge clk);
    wr(1'b0, dv(20, 0));  // R4: rewrite mid-phase and mid-count
    run_chk(70, 20 * 255, 8, "R4");
  endtask

  task automatic t_zero;
    wr(1'b0, dv(0, 200));
    run_chk(100, 0, 16, "R5");
  endtask

  task automatic t_x16;
    wr(1'b1, 32'h6EF7_1000);
    wr(1'b0, dv(9, 40));
    run_chk(400, 9 * 255 + 40, 16, "R6");
  endtask

  task automatic t_x8;
    wr(1'b1, 32'h2673_1000);
    wr(1'b0, dv(9, 40));
    run_chk(300, 9 * 255 + 40, 8, "R7");
  endtask

  task automatic t_cfg_decode;
    wr(1'b1, 32'h2673_1000 & ~32'h00F0_0000);  // end-point field cleared: 8 mode
    wr(1'b0, dv(20, 0));
    run_chk(100, 20 * 255, 8, "R8");
    wr(1'b1, 32'h1234_5678);                     // unknown: stays 8 mode
    wr(1'b0, dv(20, 0));
    run_chk(100, 20 * 255, 8, "R8");
    wr(1'b1, 32'h6EF7_1000 | 32'h00F0_0000);     // field set: 16 mode
    wr(1'b0, dv(20, 0));
    run_chk(140, 20 * 255, 16, "R8");
  endtask

  task automatic t_fast;
    wr(1'b1, 32'h6EF7_1000);
    wr(1'b0, dv(2, 0));
    run_chk(64, 2 * 255, 16, "R9");
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_default_mode();
    t_integer();
    t_fraction();
    t_phase_reset();
    t_zero();
    t_x16();
    t_x8();
    t_cfg_decode();
    t_fast();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule